// File: doc/BRIEF.md
# Per-Port FIFO Status Calendar Generator

This block produces the 2-bit flow-control code that a packet receive interface sends back to its transmitter for each port. For every provisioned port it compares a FIFO fill level against two thresholds, a low mark and a high mark, both set separately for each port. It then reports whether the port is starving, hungry or satisfied. It also has a small status memory with one entry per port, loaded through an address/value/valid write port. A per-port select bit decides whether that port's code comes from the threshold comparison or from the memory.

The serial status channel asks for one slot at a time with a single-cycle request strobe. The block keeps the calendar position itself. It walks slots 0, 1, … up to the programmed calendar length minus one and then wraps. The code for the requested slot is registered and comes out one cycle after the request, together with the slot number and a valid pulse. In shared-buffer mode all ports take their status from one common fill level. If either of two overflow flags is high, every port reports satisfied.

Top module: `pcal_top`

## Requirements
- R1: Codes are STARVING = 2'b00, HUNGRY = 2'b01 and SATISFIED = 2'b10. The fill level maps to SATISFIED when it is >= the high mark, otherwise to STARVING when it is <= the low mark, otherwise to HUNGRY. When the marks overlap, the high mark wins. 2'b11 never appears on `stat` while `stat_vld` is high.
- R2: Port p uses its own level and its own marks. Each of these sits in bits [p*LVL_W +: LVL_W] of `fill_lvl`, `lo_mark` and `hi_mark`.
- R3: While `shared_mode` is 1, every port compares `shared_lvl` against that port's own marks, and `fill_lvl` is ignored.
- R4: While `ovf_cdc` or `ovf_buf` is high in a request cycle, the reported code is SATISFIED whatever the port's source.
- R5: When `ext_sel[p]` is 1, slot p reports the status memory entry for port p instead of the computed code.
- R6: A write (`ext_wr_vld` high) stores `ext_wr_stat` at `ext_wr_addr`. Writes may come in any address order. A write carrying 2'b11 leaves the entry unchanged. A request in the same cycle as a write still sees the old value; the next request sees the new one.
- R7: A write to an address at or above the calendar length is stored, but it is never reported until the calendar length grows to cover it.
- R8: After reset, every status memory entry holds STARVING.
- R9: Each request reports the current slot and then advances it by one. The slot wraps from length-1 to 0. A `cal_len` of 0 acts as 1, and a value above NPORTS acts as NPORTS. A slot left at or beyond a shortened length restarts at 0.
- R10: `stat_vld` is high exactly in the cycle after a request. Without a request, `stat` and `stat_slot` hold their last values.
- R11: Reset clears `stat` to 2'b00, `stat_slot` to 0 and `stat_vld` to 0, and the next request serves slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shared_mode | input | 1 | 1: all ports use `shared_lvl` |
| fill_lvl | input | NPORTS*LVL_W | Per-port fill levels |
| shared_lvl | input | LVL_W | Common fill level |
| lo_mark | input | NPORTS*LVL_W | Per-port almost-empty marks |
| hi_mark | input | NPORTS*LVL_W | Per-port almost-full marks |
| ovf_cdc | input | 1 | Clock-crossing buffer overflow |
| ovf_buf | input | 1 | Main buffer overflow |
| ext_sel | input | NPORTS | Per-port source select, 1 = memory |
| ext_wr_vld | input | 1 | Status memory write strobe |
| ext_wr_addr | input | AW | Status memory write address |
| ext_wr_stat | input | 2 | Status memory write value |
| cal_len | input | CLW | Calendar length in slots |
| slot_req | input | 1 | Request the next calendar slot |
| stat | output | 2 | Registered status code |
| stat_slot | output | AW | Slot that `stat` belongs to |
| stat_vld | output | 1 | One-cycle valid for `stat` |

## Verification
The slot-range property assumes `cal_len` lies between 1 and NPORTS and is steady across a request. The directed tests change the length only between requests, and they hold the out-of-range values 0 and 5 only for runs that check the clamping at the ports. The overflow and valid-pulse properties assume the request strobe and the overflow flags are steady around the clock edge. The bench meets this by driving every input on the falling edge.

// File: rtl/pcal_pkg.sv
package pcal_pkg;
    typedef enum logic [1:0] {
        ST_STARVE = 2'b00,
        ST_HUNGRY = 2'b01,
        ST_SATED  = 2'b10,
        ST_FRAME  = 2'b11
    } pstat_e;
endpackage

// File: rtl/pcal_thr_cmp.sv
module pcal_thr_cmp #(
    parameter int LVL_W = 10
) (
    input  logic [LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0] lo,
    input  logic [LVL_W-1:0] hi,
    output pcal_pkg::pstat_e code
);
    // high mark checked first so it wins on overlap
    always_comb begin
        if (lvl >= hi)      code = pcal_pkg::ST_SATED;
        else if (lvl <= lo) code = pcal_pkg::ST_STARVE;
        else                code = pcal_pkg::ST_HUNGRY;
    end
endmodule

// File: rtl/pcal_ext_mem.sv
module pcal_ext_mem #(
    parameter int NPORTS = 4,
    parameter int AW     = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_vld,
    input  logic [AW-1:0]          wr_addr,
    input  logic [1:0]             wr_stat,
    output logic [NPORTS-1:0][1:0] ent
);
    typedef struct packed {
        logic [NPORTS-1:0][1:0] ent;
    } mem_t;

    mem_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_vld && wr_stat != 2'b11 && int'(wr_addr) < NPORTS)
            st_d.ent[wr_addr] = wr_stat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ent = st_q.ent;
endmodule

// File: rtl/pcal_cal_seq.sv
module pcal_cal_seq #(
    parameter int NPORTS = 4,
    parameter int AW     = 2,
    parameter int CLW    = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CLW-1:0] cal_len,
    input  logic           adv,
    output logic [AW-1:0]  cur_idx
);
    localparam logic [CLW-1:0] LEN_MAX = CLW'(NPORTS);

    typedef struct packed {
        logic [CLW-1:0] idx;
    } seq_t;

    seq_t           st_d, st_q;
    logic [CLW-1:0] len_eff;
    logic [CLW-1:0] eff;

    always_comb begin
        if (cal_len == '0)          len_eff = CLW'(1);
        else if (cal_len > LEN_MAX) len_eff = LEN_MAX;
        else                        len_eff = cal_len;
        eff  = (st_q.idx >= len_eff) ? '0 : st_q.idx;
        st_d = st_q;
        if (adv)
            st_d.idx = (eff == len_eff - CLW'(1)) ? '0 : eff + CLW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_idx = eff[AW-1:0];
endmodule

// File: rtl/pcal_top.sv
module pcal_top #(
    parameter int NPORTS = 4,
    parameter int LVL_W  = 10,
    parameter int AW     = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    parameter int CLW    = $clog2(NPORTS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shared_mode,
    input  logic [NPORTS*LVL_W-1:0] fill_lvl,
    input  logic [LVL_W-1:0]        shared_lvl,
    input  logic [NPORTS*LVL_W-1:0] lo_mark,
    input  logic [NPORTS*LVL_W-1:0] hi_mark,
    input  logic                    ovf_cdc,
    input  logic                    ovf_buf,
    input  logic [NPORTS-1:0]       ext_sel,
    input  logic                    ext_wr_vld,
    input  logic [AW-1:0]           ext_wr_addr,
    input  logic [1:0]              ext_wr_stat,
    input  logic [CLW-1:0]          cal_len,
    input  logic                    slot_req,
    output logic [1:0]              stat,
    output logic [AW-1:0]           stat_slot,
    output logic                    stat_vld
);
    import pcal_pkg::*;

    typedef struct packed {
        pstat_e        stat;
        logic [AW-1:0] slot;
        logic          vld;
    } out_t;

    out_t                   st_d, st_q;
    logic [AW-1:0]          cur_idx;
    logic [NPORTS-1:0][1:0] ext_ent;
    pstat_e                 calc_code [NPORTS];
    pstat_e                 pick;

    pcal_cal_seq #(.NPORTS(NPORTS), .AW(AW), .CLW(CLW)) u_seq (
        .clk(clk), .rst_n(rst_n), .cal_len(cal_len),
        .adv(slot_req), .cur_idx(cur_idx)
    );

    pcal_ext_mem #(.NPORTS(NPORTS), .AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_vld(ext_wr_vld),
        .wr_addr(ext_wr_addr), .wr_stat(ext_wr_stat), .ent(ext_ent)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic [LVL_W-1:0] lvl;
        assign lvl = shared_mode ? shared_lvl : fill_lvl[p*LVL_W +: LVL_W];
        pcal_thr_cmp #(.LVL_W(LVL_W)) u_cmp (
            .lvl(lvl),
            .lo(lo_mark[p*LVL_W +: LVL_W]),
            .hi(hi_mark[p*LVL_W +: LVL_W]),
            .code(calc_code[p])
        );
    end

    always_comb begin
        if (ovf_cdc || ovf_buf)  pick = ST_SATED;
        else if (ext_sel[cur_idx]) pick = pstat_e'(ext_ent[cur_idx]);
        else                     pick = calc_code[cur_idx];
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (slot_req) begin
            st_d.stat = pick;
            st_d.slot = cur_idx;
            st_d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{stat: ST_STARVE, slot: '0, vld: 1'b0};
        else        st_q <= st_d;
    end

    assign stat      = st_q.stat;
    assign stat_slot = st_q.slot;
    assign stat_vld  = st_q.vld;
endmodule

// File: rtl/pcal_chk.sv
module pcal_chk #(
    parameter int NPORTS = 4,
    parameter int AW     = 2,
    parameter int CLW    = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           slot_req,
    input logic           ovf_cdc,
    input logic           ovf_buf,
    input logic [CLW-1:0] cal_len,
    input logic [1:0]     stat,
    input logic [AW-1:0]  stat_slot,
    input logic           stat_vld
);
    // R10
    vld_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req |=> stat_vld);
    // R10
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_req |=> !stat_vld);
    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_req |=> ($stable(stat) && $stable(stat_slot)));
    // R1
    no_frame_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |-> stat != 2'b11);
    // R4
    ovf_sated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && (ovf_cdc || ovf_buf)) |=> stat == 2'b10);
    // R9
    slot_in_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && cal_len != '0 && int'(cal_len) <= NPORTS)
            |=> int'(stat_slot) < int'($past(cal_len)));
endmodule

bind pcal_top pcal_chk #(.NPORTS(NPORTS), .AW(AW), .CLW(CLW)) u_chk (
    .clk(clk), .rst_n(rst_n), .slot_req(slot_req), .ovf_cdc(ovf_cdc),
    .ovf_buf(ovf_buf), .cal_len(cal_len), .stat(stat),
    .stat_slot(stat_slot), .stat_vld(stat_vld)
);

// File: tb/pcal_top_test.sv
module pcal_top_test;
    localparam int NP = 4;
    localparam int LW = 10;
    localparam int AW = 2;
    localparam int CLW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shared_mode = 1'b0;
    logic [NP*LW-1:0] fill_lvl = '0;
    logic [LW-1:0] shared_lvl = '0;
    logic [NP*LW-1:0] lo_mark = '0;
    logic [NP*LW-1:0] hi_mark = '0;
    logic ovf_cdc = 1'b0, ovf_buf = 1'b0;
    logic [NP-1:0] ext_sel = '0;
    logic ext_wr_vld = 1'b0;
    logic [AW-1:0] ext_wr_addr = '0;
    logic [1:0] ext_wr_stat = '0;
    logic [CLW-1:0] cal_len = CLW'(4);
    logic slot_req = 1'b0;
    logic [1:0] stat;
    logic [AW-1:0] stat_slot;
    logic stat_vld;

    int n_chk = 0, n_bad = 0;
    int exp_idx = 0;
    logic [1:0] mem_m [NP];
    bit done = 0;

    always #10 clk = ~clk;

    pcal_top #(.NPORTS(NP), .LVL_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .shared_mode(shared_mode),
        .fill_lvl(fill_lvl), .shared_lvl(shared_lvl), .lo_mark(lo_mark),
        .hi_mark(hi_mark), .ovf_cdc(ovf_cdc), .ovf_buf(ovf_buf),
        .ext_sel(ext_sel), .ext_wr_vld(ext_wr_vld), .ext_wr_addr(ext_wr_addr),
        .ext_wr_stat(ext_wr_stat), .cal_len(cal_len), .slot_req(slot_req),
        .stat(stat), .stat_slot(stat_slot), .stat_vld(stat_vld)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_port(int p, int lvl, int lo, int hi);
        fill_lvl[p*LW +: LW] = LW'(lvl);
        lo_mark[p*LW +: LW]  = LW'(lo);
        hi_mark[p*LW +: LW]  = LW'(hi);
    endtask

    function automatic int len_eff();
        if (cal_len == 0) return 1;
        if (int'(cal_len) > NP) return NP;
        return int'(cal_len);
    endfunction

    function automatic int model(int p);
        int lvl;
        if (ovf_cdc || ovf_buf) return 2;
        if (ext_sel[p]) return int'(mem_m[p]);
        lvl = shared_mode ? int'(shared_lvl) : int'(fill_lvl[p*LW +: LW]);
        if (lvl >= int'(hi_mark[p*LW +: LW])) return 2;
        if (lvl <= int'(lo_mark[p*LW +: LW])) return 0;
        return 1;
    endfunction

    // one request; checks code, slot and valid; returns slot served
    task automatic do_req(string req, output int slot);
        int e_slot, e_stat;
        e_slot = (exp_idx >= len_eff()) ? 0 : exp_idx;
        e_stat = model(e_slot);
        @(negedge clk) slot_req = 1'b1;
        @(negedge clk) slot_req = 1'b0;
        check(req, int'(stat), e_stat);
        check(req, int'(stat_slot), e_slot);
        check(req, int'(stat_vld), 1);
        exp_idx = (e_slot == len_eff() - 1) ? 0 : e_slot + 1;
        slot = e_slot;
    endtask

    task automatic wr(int a, int v);
        @(negedge clk);
        ext_wr_vld = 1'b1; ext_wr_addr = AW'(a); ext_wr_stat = 2'(v);
        @(negedge clk) ext_wr_vld = 1'b0;
        if (v != 3) mem_m[a] = 2'(v);
    endtask

    task automatic t_reset();
        int s;
        check("R11", int'(stat), 0);
        check("R11", int'(stat_slot), 0);
        check("R11", int'(stat_vld), 0);
        ext_sel = '1;
        for (int i = 0; i < NP; i++) begin
            do_req("R8", s);
            if (i == 0) check("R11", s, 0);
        end
        ext_sel = '0;
    endtask

    task automatic t_thresh();
        int s;
        set_port(0, 5, 10, 20);   // starving
        set_port(1, 15, 10, 20);  // hungry
        set_port(2, 30, 30, 40);  // equal low mark -> starving
        set_port(3, 50, 5, 50);   // equal high mark -> satisfied
        for (int i = 0; i < NP; i++) do_req("R1_R2", s);
        set_port(0, 25, 30, 20);  // overlap -> satisfied
        set_port(1, 21, 10, 20);  // just above high -> satisfied
        set_port(2, 31, 30, 40);  // just above low -> hungry
        set_port(3, 15, 30, 20);  // below both, overlap -> starving
        for (int i = 0; i < NP; i++) do_req("R1", s);
    endtask

    task automatic t_shared();
        int s;
        shared_mode = 1'b1;
        shared_lvl = LW'(12);
        set_port(0, 900, 10, 20);
        set_port(1, 0, 12, 20);
        set_port(2, 900, 5, 12);
        set_port(3, 0, 1, 100);
        for (int i = 0; i < NP; i++) do_req("R3", s);
        shared_mode = 1'b0;
    endtask

    task automatic t_ovf();
        int s;
        set_port(0, 0, 10, 20); set_port(1, 0, 10, 20);
        set_port(2, 0, 10, 20); set_port(3, 0, 10, 20);
        ovf_cdc = 1'b1; do_req("R4", s); ovf_cdc = 1'b0;
        ovf_buf = 1'b1; ext_sel = 4'b1111; do_req("R4", s);
        ovf_buf = 1'b0; do_req("R4", s); ext_sel = '0;
    endtask

    task automatic t_ext();
        int s;
        cal_len = CLW'(4);
        while (exp_idx != 0) do_req("R9", s);
        wr(2, 1); wr(0, 2); wr(3, 1); wr(1, 2);
        wr(1, 3);                      // frame code: dropped
        ext_sel = 4'b1011;
        set_port(2, 0, 10, 20);
        for (int i = 0; i < NP; i++) do_req("R5_R6", s);
        // same-cycle write and request on slot 0
        @(negedge clk);
        ext_wr_vld = 1'b1; ext_wr_addr = '0; ext_wr_stat = 2'b00;
        slot_req = 1'b1;
        @(negedge clk);
        ext_wr_vld = 1'b0; slot_req = 1'b0;
        check("R6", int'(stat), 2);
        exp_idx = 1; mem_m[0] = 2'b00;
        while (exp_idx != 0) do_req("R6", s);
        do_req("R6", s);
        ext_sel = '0;
    endtask

    task automatic t_unprov();
        int s;
        bit seen;
        cal_len = CLW'(2);
        wr(3, 2);
        ext_sel = '1;
        seen = 0;
        for (int i = 0; i < 5; i++) begin
            do_req("R7", s);
            if (s >= 2) seen = 1;
        end
        check("R7", int'(seen), 0);
        cal_len = CLW'(4);
        while (exp_idx != 3) do_req("R7", s);
        do_req("R7", s);
        check("R7", s, 3);
        ext_sel = '0;
    endtask

    task automatic t_wrap();
        int s;
        cal_len = CLW'(3);
        for (int i = 0; i < 7; i++) do_req("R9", s);
        cal_len = CLW'(0);
        do_req("R9", s); check("R9", s, 0);
        do_req("R9", s); check("R9", s, 0);
        cal_len = CLW'(5);
        for (int i = 0; i < 6; i++) do_req("R9", s);
        cal_len = CLW'(4);
    endtask

    task automatic t_idle();
        int s, hold_stat, hold_slot;
        do_req("R10", s);
        hold_stat = int'(stat); hold_slot = int'(stat_slot);
        set_port(0, 999, 1, 2); set_port(1, 999, 1, 2);
        set_port(2, 999, 1, 2); set_port(3, 999, 1, 2);
        repeat (3) @(negedge clk);
        check("R10", int'(stat_vld), 0);
        check("R10", int'(stat), hold_stat);
        check("R10", int'(stat_slot), hold_slot);
    endtask

    initial begin
        for (int i = 0; i < NP; i++) mem_m[i] = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_thresh();
        t_shared();
        t_ovf();
        t_ext();
        t_unprov();
        t_wrap();
        t_idle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule